// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor port and a slower main-memory port. Its lines are four bytes wide, so one 32-bit word fills a line. Each set has two ways. The controller detects hits, picks a victim by least-recent use, and refills a whole line on a miss before it serves the processor from the cache. Two run-time inputs choose the operating mode: one sets write-back or write-through behaviour, and the other switches the cache off so that accesses go straight to memory.

Two whole-cache commands are provided. The first drops every line at once. The second walks every line, writes back any modified one, and leaves the cache empty. The memory side uses a plain request/acknowledge handshake with one line per transfer. The set count is a parameter: 13 index bits give the 64 KB geometry, and the elaboration default is smaller.

Top module: `two_way_cache`

## Requirements
- R1: The byte address splits into three fields. Bits [1:0] are the byte in line, the next SET_W bits are the set index, and the rest is the tag (with 24 address bits and SET_W=13 that gives a 9-bit tag). `mem_addr` carries the line address {tag, set}, which is the byte address shifted right by two.
- R2: A line can sit in either way of its own set and in no other set, and at most one way of a set can match a lookup.
- R3: A read miss fetches the line from memory into the cache first, then returns the data from the cache. A repeat read of that line hits and causes no memory traffic.
- R4: A refill fills an invalid way first, trying way 0 before way 1. When both ways are valid it evicts the way that was used less recently. One bit per set tracks this, and every hit or refill updates it.
- R5: In write-back mode (`cfg_wback`=1) a write hit merges the enabled bytes into the cache, marks the line modified, and makes no memory transaction.
- R6: An evicted line is written to memory only if it is modified. That write carries the old tag's line address, the full word and `mem_be`=4'b1111. A clean victim causes no memory write.
- R7: In write-through mode every processor write becomes a memory write with the processor's byte enables. A write hit also updates the cached copy, and that copy is not marked modified.
- R8: A write miss in write-back mode refills the line and then merges the write into it. A write miss in write-through mode only writes memory and allocates nothing.
- R9: While `cfg_disable`=1 every read and write goes to memory directly. The cache contents are neither read nor changed.
- R10: `cmd_inval` in an idle cycle invalidates every line in that cycle and makes no memory traffic, so modified data is discarded. A processor request in the same cycle is dropped and gets no `cpu_done`.
- R11: `cmd_flush` sweeps the sets in ascending order, way 0 before way 1. It writes every valid modified line to memory and invalidates each line as it passes. Afterwards every access misses. `cmd_flush` takes priority over `cmd_inval` and over a request.
- R12: Reset clears every valid, modified and recency bit, so the first access to any line misses.
- R13: `cpu_busy` is high from the cycle after a request or flush is accepted until the operation ends. Completion is a one-cycle `cpu_done` pulse, with read data on `cpu_rdata`.
- R14: Once `mem_req` is raised it stays high, with address, direction, data and byte enables held stable, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_disable | input | 1 | 1: bypass the cache entirely |
| cfg_wback | input | 1 | 1: write-back, 0: write-through |
| cmd_inval | input | 1 | Invalidate-all command pulse |
| cmd_flush | input | 1 | Write-back-then-invalidate command pulse |
| cpu_req | input | 1 | Processor request, one cycle while not busy |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DW | Write data |
| cpu_be | input | DW/8 | Byte enables for writes |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| cpu_done | output | 1 | Completion pulse |
| cpu_busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | ADDR_W-2 | Line address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte enables |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
A command and a processor request can arrive in the same idle cycle. The bench drives `cmd_inval` and `cpu_req` together on one clock edge. It then checks that no `cpu_done` follows and that no memory traffic occurs. Finally it reads both the line it had asked for and a line that had been modified: both now miss, and the modified data reads back as the older memory value, which shows the invalidation won and the request was dropped.

// File: rtl/cache_pkg.sv
// Shared types for the two-way cache.
// Assumes: nothing beyond the parameters of the users.
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_BYPASS,
        ST_SWEEP
    } cstate_t;
endpackage

// File: rtl/cache_way.sv
// One way of the cache: tag and data storage plus per-set valid and modified flags.
// Assumes: a write and an invalidate never target the same set in one cycle.
// The read port is asynchronous; flags reset, tag/data arrays do not.
module cache_way #(
    parameter int SET_W = 10,
    parameter int TAG_W = 12,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_dirty,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_idx,
    input  logic             clr_all
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] valid_q;
    logic [NSETS-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q  [NSETS];
    logic [DW-1:0]    data_q [NSETS];

    // Flag update: reset/clear-all, fill/write, and single-line invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                dirty_q[wr_idx] <= wr_dirty;
            end
            if (inv_en) begin
                valid_q[inv_idx] <= 1'b0;
                dirty_q[inv_idx] <= 1'b0;
            end
        end
    end

    // Tag and data storage write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && !(inv_en && inv_idx == wr_idx)) |=> valid_q[$past(wr_idx)]); // R3
endmodule

// File: rtl/cache_lru.sv
// Recency tracking: one bit per set naming the way to replace next.
// Assumes: touch and clear do not target the same set in one cycle.
module cache_lru #(
    parameter int SET_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_idx,
    output logic             rd_victim,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_idx,
    input  logic             clr_all
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] lru_q;

    // Point each set at the way not used most recently.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            lru_q <= '0;
        end else begin
            if (touch_en) lru_q[touch_idx] <= ~touch_way;
            if (clr_en)   lru_q[clr_idx]   <= 1'b0;
        end
    end

    assign rd_victim = lru_q[rd_idx];
endmodule

// File: rtl/two_way_cache.sv
// Two-way set-associative cache controller with write-back, write-through
// and bypass modes plus invalidate and flush sweeps.
// Assumes: one-word lines (DW bits), cfg_* stable while cpu_busy, cpu_req
// only when not busy, memory acknowledges each request with a single pulse.
module two_way_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 10,
    parameter int DW     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_disable,
    input  logic                       cfg_wback,
    input  logic                       cmd_inval,
    input  logic                       cmd_flush,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DW-1:0]              cpu_wdata,
    input  logic [DW/8-1:0]            cpu_be,
    output logic [DW-1:0]              cpu_rdata,
    output logic                       cpu_done,
    output logic                       cpu_busy,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-$clog2(DW/8)-1:0] mem_addr,
    output logic [DW-1:0]              mem_wdata,
    output logic [DW/8-1:0]            mem_be,
    input  logic [DW-1:0]              mem_rdata,
    input  logic                       mem_ack
);
    localparam int BE_W   = DW / 8;
    localparam int OFF_W  = $clog2(BE_W);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int TAG_W  = LINE_W - SET_W;
    localparam int NWAYS  = 2;

    cstate_t           state;
    cstate_t           nxt;
    logic              r_we, r_wback, r_vic, r_sway, r_done;
    logic [LINE_W-1:0] r_line;
    logic [DW-1:0]     r_wdata, r_rdata;
    logic [BE_W-1:0]   r_be;
    logic [SET_W-1:0]  r_idx;

    logic [SET_W-1:0]  r_set;
    logic [TAG_W-1:0]  r_tag;
    logic [SET_W-1:0]  rd_idx;
    logic              unused_offset;

    logic              w_valid [NWAYS];
    logic              w_dirty [NWAYS];
    logic [TAG_W-1:0]  w_tag   [NWAYS];
    logic [DW-1:0]     w_data  [NWAYS];
    logic [NWAYS-1:0]  hit, way_wr;
    logic              hit_any, hit_way, lru_vic, vic;
    logic [DW-1:0]     wr_data, fin_data;
    logic              wr_dirty, touch_en, sweep_adv, finish, inval_go, accept;

    assign r_set         = r_line[SET_W-1:0];
    assign r_tag         = r_line[LINE_W-1 -: TAG_W];
    assign rd_idx        = (state == ST_SWEEP) ? r_idx : r_set;
    assign unused_offset = ^cpu_addr[OFF_W-1:0];

    // Merge enabled bytes of a new word over an old one.
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [BE_W-1:0] be);
        logic [DW-1:0] res;
        res = old_w;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
        return res;
    endfunction

    generate
        for (genvar w = 0; w < NWAYS; w++) begin : g_way
            cache_way #(.SET_W(SET_W), .TAG_W(TAG_W), .DW(DW)) u_way (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_idx   (rd_idx),
                .rd_valid (w_valid[w]),
                .rd_dirty (w_dirty[w]),
                .rd_tag   (w_tag[w]),
                .rd_data  (w_data[w]),
                .wr_en    (way_wr[w]),
                .wr_idx   (r_set),
                .wr_tag   (r_tag),
                .wr_data  (wr_data),
                .wr_dirty (wr_dirty),
                .inv_en   (sweep_adv && (r_sway == 1'(w))),
                .inv_idx  (r_idx),
                .clr_all  (inval_go)
            );
            assign hit[w] = w_valid[w] && (w_tag[w] == r_tag);
        end
    endgenerate

    cache_lru #(.SET_W(SET_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_victim (lru_vic),
        .touch_en  (touch_en),
        .touch_idx (r_set),
        .touch_way (hit_way),
        .clr_en    (sweep_adv && r_sway),
        .clr_idx   (r_idx),
        .clr_all   (inval_go)
    );

    assign hit_any = |hit;
    assign hit_way = hit[1];
    assign vic     = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_vic);

    // Next state, memory port and storage write controls.
    always_comb begin
        nxt       = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_line;
        mem_wdata = r_wdata;
        mem_be    = r_be;
        way_wr    = '0;
        wr_data   = mem_rdata;
        wr_dirty  = 1'b0;
        touch_en  = 1'b0;
        sweep_adv = 1'b0;
        finish    = 1'b0;
        fin_data  = '0;
        inval_go  = 1'b0;
        accept    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_flush)      nxt = ST_SWEEP;
                else if (cmd_inval) inval_go = 1'b1;
                else if (cpu_req) begin
                    accept = 1'b1;
                    nxt    = cfg_disable ? ST_BYPASS : ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (hit_any) begin
                    touch_en = 1'b1;
                    if (r_we) begin
                        way_wr[hit_way] = 1'b1;
                        wr_data  = merge(w_data[hit_way], r_wdata, r_be);
                        wr_dirty = r_wback || w_dirty[hit_way];
                        if (r_wback) begin
                            finish = 1'b1;
                            nxt    = ST_IDLE;
                        end else begin
                            nxt = ST_WTHRU;
                        end
                    end else begin
                        finish   = 1'b1;
                        fin_data = w_data[hit_way];
                        nxt      = ST_IDLE;
                    end
                end else if (r_we && !r_wback) begin
                    nxt = ST_WTHRU;
                end else if (w_valid[vic] && w_dirty[vic]) begin
                    nxt = ST_EVICT;
                end else begin
                    nxt = ST_FILL;
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {w_tag[r_vic], r_set};
                mem_wdata = w_data[r_vic];
                mem_be    = '1;
                if (mem_ack) nxt = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    way_wr[r_vic] = 1'b1;
                    nxt           = ST_LOOK;
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                mem_req = 1'b1;
                mem_we  = r_we;
                if (mem_ack) begin
                    finish   = 1'b1;
                    fin_data = mem_rdata;
                    nxt      = ST_IDLE;
                end
            end
            ST_SWEEP: begin
                if (w_valid[r_sway] && w_dirty[r_sway]) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {w_tag[r_sway], r_idx};
                    mem_wdata = w_data[r_sway];
                    mem_be    = '1;
                    sweep_adv = mem_ack;
                end else begin
                    sweep_adv = 1'b1;
                end
                if (sweep_adv && r_sway && (&r_idx)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, captured request, victim, sweep position and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_we    <= 1'b0;
            r_wback <= 1'b0;
            r_line  <= '0;
            r_wdata <= '0;
            r_be    <= '0;
            r_vic   <= 1'b0;
            r_idx   <= '0;
            r_sway  <= 1'b0;
            r_done  <= 1'b0;
            r_rdata <= '0;
        end else begin
            state  <= nxt;
            r_done <= finish;
            if (finish) r_rdata <= fin_data;
            if (accept) begin
                r_we    <= cpu_we;
                r_wback <= cfg_wback;
                r_line  <= cpu_addr[ADDR_W-1:OFF_W];
                r_wdata <= cpu_wdata;
                r_be    <= cpu_be;
            end
            if (state == ST_LOOK && !hit_any) r_vic <= vic;
            if (state == ST_IDLE && cmd_flush) begin
                r_idx  <= '0;
                r_sway <= 1'b0;
            end else if (sweep_adv) begin
                r_sway <= ~r_sway;
                if (r_sway) r_idx <= r_idx + 1'b1;
            end
        end
    end

    assign cpu_busy  = (state != ST_IDLE);
    assign cpu_done  = r_done;
    assign cpu_rdata = r_rdata;

    AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOK) |-> $onehot0(hit)); // R2
    AST_WB_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOK && hit_any && r_we && r_wback) |=> !mem_req); // R5
    AST_EVICT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT) |-> (w_valid[r_vic] && w_dirty[r_vic])); // R6
    AST_SWEEP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && $past(state) == ST_SWEEP) |-> (r_idx >= $past(r_idx))); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_be))); // R14
endmodule

// File: tb/tb_two_way_cache.sv
// Directed bench for two_way_cache with a small set count and a latency-2 memory model.
module tb_two_way_cache;
    localparam int ADDR_W = 24;
    localparam int SET_W  = 4;
    localparam int DW     = 32;
    localparam int LINE_W = ADDR_W - 2;
    localparam int TAG_W  = LINE_W - SET_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_disable = 1'b0, cfg_wback = 1'b1;
    logic              cmd_inval = 1'b0, cmd_flush = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DW-1:0]     cpu_wdata = '0;
    logic [3:0]        cpu_be = '0;
    logic [DW-1:0]     cpu_rdata;
    logic              cpu_done, cpu_busy;
    logic              mem_req, mem_we;
    logic [LINE_W-1:0] mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic [3:0]        mem_be;
    logic [DW-1:0]     mem_rdata = '0;
    logic              mem_ack = 1'b0;

    int checks = 0, fails = 0;

    two_way_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_wback(cfg_wback),
        .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_busy(cpu_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #10 clk = ~clk;

    // Memory model: 256 words indexed by the low line-address byte, ack after two waits.
    logic [DW-1:0] mem [256];
    int n_rd = 0, n_wr = 0, proto_err = 0, wait_cnt = 0;
    logic [LINE_W-1:0] last_rd, last_wr;
    logic [DW-1:0]     last_wd;
    logic [3:0]        last_be;
    logic [LINE_W-1:0] wlog_a [8];
    logic [DW-1:0]     wlog_d [8];
    logic              p_pend = 1'b0;
    logic [LINE_W-1:0] p_addr = '0;

    initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;

    always @(posedge clk) begin
        if (p_pend && (!mem_req || mem_addr != p_addr)) proto_err <= proto_err + 1;
        p_pend <= rst_n && mem_req && !mem_ack;
        p_addr <= mem_addr;
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 2) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    if (n_wr < 8) begin
                        wlog_a[n_wr] <= mem_addr;
                        wlog_d[n_wr] <= mem_wdata;
                    end
                    n_wr    <= n_wr + 1;
                    last_wr <= mem_addr;
                    last_wd <= mem_wdata;
                    last_be <= mem_be;
                end else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    n_rd      <= n_rd + 1;
                    last_rd   <= mem_addr;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
        logic [TAG_W-1:0] t;
        logic [SET_W-1:0] s;
        t = TAG_W'(tag);
        s = SET_W'(set);
        return {t, s, 2'b00};
    endfunction

    function automatic logic [LINE_W-1:0] ln(input int tag, input int set);
        return LINE_W'(tag * 16 + set);
    endfunction

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [3:0] be);
        logic [DW-1:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input int tag, input int set, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output logic busy_seen);
        int n;
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = mk(tag, set); cpu_wdata = wd; cpu_be = be;
        @(negedge clk);
        cpu_req = 1'b0;
        busy_seen = cpu_busy;
        n = 0;
        while (!cpu_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!cpu_done) begin
            checks++; fails++;
            $display("FAIL R13 no cpu_done actual=0 expected=1");
        end
        rd = cpu_rdata;
    endtask

    logic [31:0] rd;
    logic        bs;
    int          r0, w0;

    task automatic t_reset();
        check("R12", "busy after reset", 32'(cpu_busy), 0);
        check("R12", "mem_req after reset", 32'(mem_req), 0);
        check("R13", "done after reset", 32'(cpu_done), 0);
        r0 = n_rd;
        access(0, 1, 3, 0, 0, rd, bs);
        check("R12", "first read misses", n_rd - r0, 1);
        check("R1", "line address", 32'(last_rd), 32'(ln(1, 3)));
        check("R3", "miss data", rd, 32'hA000_0013);
        check("R13", "busy during miss", 32'(bs), 1);
        r0 = n_rd;
        access(0, 1, 3, 0, 0, rd, bs);
        check("R3", "repeat read no memory", n_rd - r0, 0);
        check("R3", "repeat read data", rd, 32'hA000_0013);
    endtask

    task automatic t_lru();
        r0 = n_rd;
        access(0, 1, 5, 0, 0, rd, bs);
        access(0, 2, 5, 0, 0, rd, bs);
        check("R2", "both ways fill", n_rd - r0, 2);
        access(0, 1, 5, 0, 0, rd, bs);
        check("R2", "way0 line kept", n_rd - r0, 2);
        access(0, 3, 5, 0, 0, rd, bs);
        r0 = n_rd;
        access(0, 1, 5, 0, 0, rd, bs);
        check("R4", "recent line survives", n_rd - r0, 0);
        check("R4", "recent line data", rd, 32'hA000_0015);
        access(0, 2, 5, 0, 0, rd, bs);
        check("R4", "older line was evicted", n_rd - r0, 1);
        access(0, 1, 5, 0, 0, rd, bs);
    endtask

    task automatic t_wback();
        cfg_wback = 1'b1;
        r0 = n_rd; w0 = n_wr;
        access(1, 1, 5, 32'h1234_5678, 4'b0011, rd, bs);
        check("R5", "write hit no memory write", n_wr - w0, 0);
        check("R5", "write hit no memory read", n_rd - r0, 0);
        access(0, 1, 5, 0, 0, rd, bs);
        check("R5", "merged data", rd, mrg(32'hA000_0015, 32'h1234_5678, 4'b0011));
        access(0, 4, 5, 0, 0, rd, bs);
        check("R6", "clean victim no write", n_wr - w0, 0);
        access(0, 5, 5, 0, 0, rd, bs);
        check("R6", "dirty victim one write", n_wr - w0, 1);
        check("R6", "evict address", 32'(last_wr), 32'(ln(1, 5)));
        check("R6", "evict data", last_wd, 32'hA000_5678);
        check("R6", "evict be", 32'(last_be), 32'hF);
    endtask

    task automatic t_wthru();
        cfg_wback = 1'b0;
        r0 = n_rd; w0 = n_wr;
        access(1, 4, 5, 32'hCAFE_BABE, 4'b1100, rd, bs);
        check("R7", "hit writes memory", n_wr - w0, 1);
        check("R7", "write be", 32'(last_be), 32'hC);
        check("R7", "write address", 32'(last_wr), 32'(ln(4, 5)));
        access(0, 4, 5, 0, 0, rd, bs);
        check("R7", "cache updated", rd, 32'hCAFE_0045);
        check("R7", "no refill", n_rd - r0, 0);
        access(1, 6, 9, 32'h1111_2222, 4'b1111, rd, bs);
        check("R8", "wt miss no fill", n_rd - r0, 0);
        check("R8", "wt miss writes", n_wr - w0, 2);
        access(0, 6, 9, 0, 0, rd, bs);
        check("R8", "wt miss not allocated", n_rd - r0, 1);
        check("R8", "wt miss data", rd, 32'h1111_2222);
    endtask

    task automatic t_alloc();
        cfg_wback = 1'b1;
        r0 = n_rd; w0 = n_wr;
        access(1, 7, 10, 32'h5555_AAAA, 4'b0001, rd, bs);
        check("R8", "wb miss refills", n_rd - r0, 1);
        check("R8", "wb miss no write", n_wr - w0, 0);
        access(0, 7, 10, 0, 0, rd, bs);
        check("R8", "wb allocated data", rd, 32'hA000_00AA);
        check("R8", "wb allocated hit", n_rd - r0, 1);
    endtask

    task automatic t_disable();
        cfg_disable = 1'b1;
        r0 = n_rd; w0 = n_wr;
        access(0, 7, 10, 0, 0, rd, bs);
        check("R9", "bypass read goes to memory", n_rd - r0, 1);
        check("R9", "bypass read data", rd, 32'hA000_007A);
        access(1, 7, 10, 32'h7777_7777, 4'b1111, rd, bs);
        check("R9", "bypass write to memory", n_wr - w0, 1);
        cfg_disable = 1'b0;
        access(0, 7, 10, 0, 0, rd, bs);
        check("R9", "cache untouched data", rd, 32'hA000_00AA);
        check("R9", "cache untouched hit", n_rd - r0, 1);
    endtask

    task automatic t_inval();
        int dn;
        r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cmd_inval = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(1, 3);
        @(negedge clk);
        cmd_inval = 1'b0; cpu_req = 1'b0;
        dn = 0;
        for (int i = 0; i < 10; i++) begin
            if (cpu_done) dn++;
            @(negedge clk);
        end
        check("R10", "request dropped", dn, 0);
        check("R10", "no memory traffic", (n_rd - r0) + (n_wr - w0), 0);
        access(0, 7, 10, 0, 0, rd, bs);
        check("R10", "dirty line discarded", rd, 32'h7777_7777);
        access(0, 1, 3, 0, 0, rd, bs);
        check("R10", "lines invalid", n_rd - r0, 2);
    endtask

    task automatic t_flush();
        int n;
        cfg_wback = 1'b1;
        access(1, 8, 6, 32'hD000_0001, 4'b1111, rd, bs);
        access(1, 9, 6, 32'hD000_0002, 4'b1111, rd, bs);
        access(1, 8, 1, 32'hD000_0003, 4'b1111, rd, bs);
        w0 = n_wr;
        @(negedge clk);
        cmd_flush = 1'b1;
        @(negedge clk);
        cmd_flush = 1'b0;
        check("R13", "busy during sweep", 32'(cpu_busy), 1);
        n = 0;
        while (cpu_busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        check("R11", "three writebacks", n_wr - w0, 3);
        check("R11", "first set1", 32'(wlog_a[w0]), 32'(ln(8, 1)));
        check("R11", "second set6 way0", 32'(wlog_a[w0+1]), 32'(ln(8, 6)));
        check("R11", "third set6 way1", 32'(wlog_a[w0+2]), 32'(ln(9, 6)));
        check("R11", "third data", wlog_d[w0+2], 32'hD000_0002);
        r0 = n_rd;
        access(0, 1, 3, 0, 0, rd, bs);
        check("R11", "clean line invalidated", n_rd - r0, 1);
        access(0, 8, 6, 0, 0, rd, bs);
        check("R11", "flushed data in memory", rd, 32'hD000_0001);
        check("R11", "flushed line invalidated", n_rd - r0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lru();
        t_wback();
        t_wthru();
        t_alloc();
        t_disable();
        t_inval();
        t_flush();
        check("R14", "request held until ack", proto_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule